// File: doc/BRIEF.md
# Out-of-Order Issue Window with In-Order Retirement

This block keeps renamed instructions in one circular array of slots from the moment decode hands them over until they retire. The index of the slot an instruction occupies becomes the tag that names its destination. Each source operand is stored either as a value that is already known or as the tag of the older slot that will produce it. A result broadcast on the completion port carries a tag and a data word. Every waiting source that names that tag takes the data and becomes present. The same broadcast marks the producing slot as finished.

In each cycle the window sends at most one slot to execution: the oldest slot, counted from the head, whose two sources are both present and which has not yet been sent. Slots leave in program order at the head, and only a finished head slot can leave. A clean retirement presents the destination register and result for the register-file write. A head slot that finished with an exception cause raises the exception output with that cause and empties the whole window: every slot is freed and both pointers return to zero.

Each slot runs its own four-state machine. FREE goes to WAIT on allocation. WAIT goes to EXEC when the slot is dispatched. EXEC goes to DONE when its completion arrives. DONE goes back to FREE on retirement. A flush sends every state to FREE.

Top module: `rob_issue_window`

## Requirements
- R1: After reset the window is empty: alloc_ready is 1, alloc_tag is 0, and disp_valid, ret_valid and exc_valid are all 0.
- R2: An accepted allocation takes the slot named by alloc_tag. Successive allocations receive tags that count up by one, modulo DEPTH.
- R3: Once DEPTH slots are occupied, alloc_ready is 0 and alloc_valid is ignored. An ignored request occupies no slot, so the next accepted allocation after the window drains receives the expected tag.
- R4: A slot is dispatched only while both its sources are present. A slot with a missing source is not dispatched until a matching broadcast arrives, and it becomes dispatchable in the cycle after that broadcast.
- R5: When several slots are ready, disp_tag names the one nearest the head in program order. The others follow in later cycles, in age order.
- R6: A slot is dispatched exactly once: disp_valid names it for a single cycle.
- R7: A broadcast whose tag equals a waiting source's tag replaces that source with the broadcast data, which then appears on disp_opa or disp_opb.
- R8: A broadcast in the same cycle as an allocation is also compared with the incoming sources, so a source waiting on that tag is captured as present.
- R9: Retirement happens in program order, one slot per cycle, and only when the head slot has completed. ret_valid, ret_dst_reg and ret_data present each result in allocation order, even when completions arrive out of order.
- R10: A head slot that completed with cpl_exc set raises exc_valid with its cause and keeps ret_valid at 0. On the following edge every slot is freed and both pointers return to 0, so no younger instruction retires and the next allocation receives tag 0.
- R11: When a source is marked not present, the low TAG_W bits of its field carry the tag (slot index) of its producer. When it is present, the field carries the operand value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_op | input | OP_W | Opcode of the offered instruction |
| alloc_s1_rdy | input | 1 | Source 1 is present (value) rather than pending (tag) |
| alloc_s1_fld | input | DATA_W | Source 1 value, or producer tag in the low bits |
| alloc_s2_rdy | input | 1 | Source 2 is present |
| alloc_s2_fld | input | DATA_W | Source 2 value, or producer tag in the low bits |
| alloc_dst_en | input | 1 | Instruction writes a destination register |
| alloc_dst_reg | input | REG_W | Destination register number |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_tag | output | TAG_W | Tag the next accepted instruction receives |
| disp_valid | output | 1 | A slot is sent to execution this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched slot |
| disp_op | output | OP_W | Its opcode |
| disp_opa | output | DATA_W | Its source 1 value |
| disp_opb | output | DATA_W | Its source 2 value |
| cpl_valid | input | 1 | Result broadcast |
| cpl_tag | input | TAG_W | Tag of the completing slot |
| cpl_data | input | DATA_W | Result value |
| cpl_exc | input | 1 | The completing instruction raised an exception |
| cpl_cause | input | CAUSE_W | Exception cause code |
| ret_valid | output | 1 | Head slot retires cleanly this cycle |
| ret_dst_en | output | 1 | Retiring instruction writes a register |
| ret_dst_reg | output | REG_W | Register to write |
| ret_data | output | DATA_W | Value to write |
| exc_valid | output | 1 | Head slot retires with an exception; window flushes |
| exc_cause | output | CAUSE_W | Cause of that exception |

## Verification
The assertions assume that execution is well behaved. A broadcast names only a slot that has been dispatched and has not yet completed, and it does so once. A pending source names an older slot that is still live. Under these assumptions a slot in EXEC can move only to DONE or FREE, and a slot never leaves WAIT unless its operands are present. The stimulus keeps to these assumptions. It issues a completion for a tag only after seeing that tag on the dispatch port, and it builds each pending source from a tag it was handed earlier by alloc_tag.

// File: rtl/rob_iw_pkg.sv
package rob_iw_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_EXEC = 2'd2,
        SLOT_DONE = 2'd3
    } slot_state_e;

endpackage

// File: rtl/rob_iw_slot.sv
module rob_iw_slot
    import rob_iw_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int TAG_W   = 3,
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4,
    parameter int REG_W   = 5,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               alloc_we_i,
    input  logic [OP_W-1:0]    alloc_op_i,
    input  logic               s1_rdy_i,
    input  logic [DATA_W-1:0]  s1_fld_i,
    input  logic               s2_rdy_i,
    input  logic [DATA_W-1:0]  s2_fld_i,
    input  logic               dst_en_i,
    input  logic [REG_W-1:0]   dst_reg_i,
    input  logic               disp_take_i,
    input  logic               cpl_valid_i,
    input  logic [TAG_W-1:0]   cpl_tag_i,
    input  logic [DATA_W-1:0]  cpl_data_i,
    input  logic               cpl_exc_i,
    input  logic [CAUSE_W-1:0] cpl_cause_i,
    input  logic               retire_i,
    output slot_state_e        state_o,
    output logic               ready_o,
    output logic [OP_W-1:0]    op_o,
    output logic [DATA_W-1:0]  opa_o,
    output logic [DATA_W-1:0]  opb_o,
    output logic               dst_en_o,
    output logic [REG_W-1:0]   dst_reg_o,
    output logic [DATA_W-1:0]  res_o,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(IDX);

    slot_state_e        state_q, state_d;
    logic               p1_q, p2_q;
    logic [DATA_W-1:0]  f1_q, f2_q;
    logic [OP_W-1:0]    op_q;
    logic               dst_en_q;
    logic [REG_W-1:0]   dst_reg_q;
    logic [DATA_W-1:0]  res_q;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;

    logic cpl_mine;
    logic new1_hit, new2_hit;
    logic wake1, wake2;

    assign cpl_mine = cpl_valid_i && (cpl_tag_i == MY_TAG);
    assign new1_hit = cpl_valid_i && !s1_rdy_i && (s1_fld_i[TAG_W-1:0] == cpl_tag_i);
    assign new2_hit = cpl_valid_i && !s2_rdy_i && (s2_fld_i[TAG_W-1:0] == cpl_tag_i);
    assign wake1    = cpl_valid_i && (state_q == SLOT_WAIT) && !p1_q
                      && (f1_q[TAG_W-1:0] == cpl_tag_i);
    assign wake2    = cpl_valid_i && (state_q == SLOT_WAIT) && !p2_q
                      && (f2_q[TAG_W-1:0] == cpl_tag_i);

    // next-state logic of the slot machine
    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = SLOT_FREE;
        end else begin
            unique case (state_q)
                SLOT_FREE: if (alloc_we_i)  state_d = SLOT_WAIT;
                SLOT_WAIT: if (disp_take_i) state_d = SLOT_EXEC;
                SLOT_EXEC: if (cpl_mine)    state_d = SLOT_DONE;
                SLOT_DONE: if (retire_i)    state_d = SLOT_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // operand, destination and result storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_q      <= 1'b0;
            p2_q      <= 1'b0;
            f1_q      <= '0;
            f2_q      <= '0;
            op_q      <= '0;
            dst_en_q  <= 1'b0;
            dst_reg_q <= '0;
            res_q     <= '0;
            exc_q     <= 1'b0;
            cause_q   <= '0;
        end else if (!flush_i) begin
            if (state_q == SLOT_FREE && alloc_we_i) begin
                op_q      <= alloc_op_i;
                dst_en_q  <= dst_en_i;
                dst_reg_q <= dst_reg_i;
                exc_q     <= 1'b0;
                cause_q   <= '0;
                p1_q      <= s1_rdy_i | new1_hit;
                f1_q      <= new1_hit ? cpl_data_i : s1_fld_i;
                p2_q      <= s2_rdy_i | new2_hit;
                f2_q      <= new2_hit ? cpl_data_i : s2_fld_i;
            end else begin
                if (wake1) begin
                    p1_q <= 1'b1;
                    f1_q <= cpl_data_i;
                end
                if (wake2) begin
                    p2_q <= 1'b1;
                    f2_q <= cpl_data_i;
                end
                if (state_q == SLOT_EXEC && cpl_mine) begin
                    res_q   <= cpl_data_i;
                    exc_q   <= cpl_exc_i;
                    cause_q <= cpl_cause_i;
                end
            end
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        ready_o   = (state_q == SLOT_WAIT) && p1_q && p2_q;
        op_o      = op_q;
        opa_o     = f1_q;
        opb_o     = f2_q;
        dst_en_o  = dst_en_q;
        dst_reg_o = dst_reg_q;
        res_o     = res_q;
        exc_o     = exc_q;
        cause_o   = cause_q;
    end

    // R6
    exec_no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_EXEC) |=> (state_q != SLOT_WAIT));

    // R4
    no_early_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && !(p1_q && p2_q)) |=> (state_q != SLOT_EXEC));

    // R7
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && p1_q && p2_q && !flush_i) |=> (p1_q && p2_q));

endmodule

// File: rtl/rob_iw_pick.sv
module rob_iw_pick #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] ready_i,
    input  logic [TAG_W-1:0] head_i,
    output logic             pick_v_o,
    output logic [TAG_W-1:0] pick_idx_o
);

    // scan from the head so the first hit is the oldest ready slot
    always_comb begin
        pick_v_o   = 1'b0;
        pick_idx_o = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (!pick_v_o && ready_i[TAG_W'(head_i + TAG_W'(j))]) begin
                pick_v_o   = 1'b1;
                pick_idx_o = TAG_W'(head_i + TAG_W'(j));
            end
        end
    end

    // R5
    pick_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_v_o |-> ready_i[pick_idx_o]);

    // R4
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i == '0) |-> !pick_v_o);

endmodule

// File: rtl/rob_iw_ptrs.sv
module rob_iw_ptrs #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire_i,
    input  logic             retire_i,
    input  logic             flush_i,
    output logic [TAG_W-1:0] head_o,
    output logic [TAG_W-1:0] tail_o,
    output logic             full_o
);

    logic [TAG_W:0] head_q, tail_q;
    logic           empty;

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc_fire_i) tail_q <= tail_q + 1'b1;
            if (retire_i)     head_q <= head_q + 1'b1;
        end
    end

    assign head_o = head_q[TAG_W-1:0];
    assign tail_o = tail_q[TAG_W-1:0];
    assign full_o = (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]) && (head_q[TAG_W] != tail_q[TAG_W]);
    assign empty  = (head_q == tail_q);

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !retire_i && !flush_i) |=> full_o);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (empty && head_q == '0));

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !flush_i) |=> $stable(head_q));

endmodule

// File: rtl/rob_issue_window.sv
module rob_issue_window
    import rob_iw_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 16,
    parameter int OP_W    = 4,
    parameter int REG_W   = 5,
    parameter int CAUSE_W = 4,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [OP_W-1:0]    alloc_op,
    input  logic               alloc_s1_rdy,
    input  logic [DATA_W-1:0]  alloc_s1_fld,
    input  logic               alloc_s2_rdy,
    input  logic [DATA_W-1:0]  alloc_s2_fld,
    input  logic               alloc_dst_en,
    input  logic [REG_W-1:0]   alloc_dst_reg,
    output logic               alloc_ready,
    output logic [TAG_W-1:0]   alloc_tag,
    output logic               disp_valid,
    output logic [TAG_W-1:0]   disp_tag,
    output logic [OP_W-1:0]    disp_op,
    output logic [DATA_W-1:0]  disp_opa,
    output logic [DATA_W-1:0]  disp_opb,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    input  logic [DATA_W-1:0]  cpl_data,
    input  logic               cpl_exc,
    input  logic [CAUSE_W-1:0] cpl_cause,
    output logic               ret_valid,
    output logic               ret_dst_en,
    output logic [REG_W-1:0]   ret_dst_reg,
    output logic [DATA_W-1:0]  ret_data,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);

    slot_state_e        state_a   [DEPTH];
    logic [OP_W-1:0]    op_a      [DEPTH];
    logic [DATA_W-1:0]  opa_a     [DEPTH];
    logic [DATA_W-1:0]  opb_a     [DEPTH];
    logic               dst_en_a  [DEPTH];
    logic [REG_W-1:0]   dst_reg_a [DEPTH];
    logic [DATA_W-1:0]  res_a     [DEPTH];
    logic               exc_a     [DEPTH];
    logic [CAUSE_W-1:0] cause_a   [DEPTH];
    logic [DEPTH-1:0]   ready_vec;

    logic [TAG_W-1:0] head, tail, pick_idx;
    logic             full, pick_v;
    logic             head_done, flush, retire, alloc_fire;

    assign head_done  = (state_a[head] == SLOT_DONE);
    assign flush      = head_done && exc_a[head];
    assign retire     = head_done && !exc_a[head];
    assign alloc_fire = alloc_valid && alloc_ready;

    rob_iw_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire_i (alloc_fire),
        .retire_i     (retire),
        .flush_i      (flush),
        .head_o       (head),
        .tail_o       (tail),
        .full_o       (full)
    );

    rob_iw_pick #(.DEPTH(DEPTH)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_vec),
        .head_i     (head),
        .pick_v_o   (pick_v),
        .pick_idx_o (pick_idx)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_iw_slot #(
            .IDX     (i),
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W),
            .OP_W    (OP_W),
            .REG_W   (REG_W),
            .CAUSE_W (CAUSE_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush),
            .alloc_we_i  (alloc_fire && (tail == TAG_W'(i))),
            .alloc_op_i  (alloc_op),
            .s1_rdy_i    (alloc_s1_rdy),
            .s1_fld_i    (alloc_s1_fld),
            .s2_rdy_i    (alloc_s2_rdy),
            .s2_fld_i    (alloc_s2_fld),
            .dst_en_i    (alloc_dst_en),
            .dst_reg_i   (alloc_dst_reg),
            .disp_take_i (disp_valid && (pick_idx == TAG_W'(i))),
            .cpl_valid_i (cpl_valid),
            .cpl_tag_i   (cpl_tag),
            .cpl_data_i  (cpl_data),
            .cpl_exc_i   (cpl_exc),
            .cpl_cause_i (cpl_cause),
            .retire_i    (retire && (head == TAG_W'(i))),
            .state_o     (state_a[i]),
            .ready_o     (ready_vec[i]),
            .op_o        (op_a[i]),
            .opa_o       (opa_a[i]),
            .opb_o       (opb_a[i]),
            .dst_en_o    (dst_en_a[i]),
            .dst_reg_o   (dst_reg_a[i]),
            .res_o       (res_a[i]),
            .exc_o       (exc_a[i]),
            .cause_o     (cause_a[i])
        );
    end

    always_comb begin
        alloc_ready = !full && !flush;
        alloc_tag   = tail;
        disp_valid  = pick_v && !flush;
        disp_tag    = pick_idx;
        disp_op     = op_a[pick_idx];
        disp_opa    = opa_a[pick_idx];
        disp_opb    = opb_a[pick_idx];
        ret_valid   = retire;
        ret_dst_en  = dst_en_a[head];
        ret_dst_reg = dst_reg_a[head];
        ret_data    = res_a[head];
        exc_valid   = flush;
        exc_cause   = cause_a[head];
    end

    // R10
    exc_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (alloc_tag == '0 && !ret_valid && !exc_valid));

endmodule

// File: tb/rob_issue_window_tb.sv
`timescale 1ns/1ps
module rob_issue_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0;
    logic [3:0]  alloc_op = 0;
    logic        alloc_s1_rdy = 0;
    logic [15:0] alloc_s1_fld = 0;
    logic        alloc_s2_rdy = 0;
    logic [15:0] alloc_s2_fld = 0;
    logic        alloc_dst_en = 0;
    logic [4:0]  alloc_dst_reg = 0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        disp_valid;
    logic [2:0]  disp_tag;
    logic [3:0]  disp_op;
    logic [15:0] disp_opa, disp_opb;
    logic        cpl_valid = 0;
    logic [2:0]  cpl_tag = 0;
    logic [15:0] cpl_data = 0;
    logic        cpl_exc = 0;
    logic [3:0]  cpl_cause = 0;
    logic        ret_valid, ret_dst_en;
    logic [4:0]  ret_dst_reg;
    logic [15:0] ret_data;
    logic        exc_valid;
    logic [3:0]  exc_cause;

    always #10 clk = ~clk;

    rob_issue_window u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_s1_rdy(alloc_s1_rdy), .alloc_s1_fld(alloc_s1_fld),
        .alloc_s2_rdy(alloc_s2_rdy), .alloc_s2_fld(alloc_s2_fld),
        .alloc_dst_en(alloc_dst_en), .alloc_dst_reg(alloc_dst_reg),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_opa(disp_opa), .disp_opb(disp_opb),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .cpl_exc(cpl_exc), .cpl_cause(cpl_cause),
        .ret_valid(ret_valid), .ret_dst_en(ret_dst_en), .ret_dst_reg(ret_dst_reg),
        .ret_data(ret_data), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    typedef struct {
        bit          is_exc;
        logic [4:0]  reg_no;
        logic [15:0] data;
        logic [3:0]  cause;
    } exp_item_t;

    exp_item_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int ret_seen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [3:0] op, input bit r1, input logic [15:0] f1,
                         input bit r2, input logic [15:0] f2, input logic [4:0] dreg,
                         input logic [15:0] exp_data, input bit push, output logic [2:0] tag);
        exp_item_t it;
        alloc_valid = 1; alloc_op = op;
        alloc_s1_rdy = r1; alloc_s1_fld = f1;
        alloc_s2_rdy = r2; alloc_s2_fld = f2;
        alloc_dst_en = 1; alloc_dst_reg = dreg;
        #1;
        chk(alloc_ready, "R2 alloc_ready", alloc_ready, 1);
        tag = alloc_tag;
        if (push) begin
            it.is_exc = 0; it.reg_no = dreg; it.data = exp_data; it.cause = 0;
            exp_q.push_back(it);
        end
        step();
        alloc_valid = 0;
        #1;
    endtask

    task automatic complete(input logic [2:0] tag, input logic [15:0] data,
                            input bit ex, input logic [3:0] cause);
        cpl_valid = 1; cpl_tag = tag; cpl_data = data; cpl_exc = ex; cpl_cause = cause;
        step();
        cpl_valid = 0; cpl_exc = 0;
        #1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ret_valid && exc_valid) begin
                checks++; errors++;
                $display("FAIL R10: ret_valid=1 with exc_valid=1 expected ret_valid=0");
            end
            if (ret_valid || exc_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9: unexpected retire reg=%0h data=%0h expected none", ret_dst_reg, ret_data);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    if (ret_valid) begin
                        ret_seen++;
                        if (e.is_exc || ret_dst_reg != e.reg_no || ret_data != e.data || !ret_dst_en) begin
                            errors++;
                            $display("FAIL R9: retire reg=%0h data=%0h expected reg=%0h data=%0h exc=%0d",
                                     ret_dst_reg, ret_data, e.reg_no, e.data, e.is_exc);
                        end
                    end else if (!e.is_exc || exc_cause != e.cause) begin
                        errors++;
                        $display("FAIL R10: exception cause=%0h expected cause=%0h exc=%0d",
                                 exc_cause, e.cause, e.is_exc);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] t;
        int rc;
        exp_item_t ei;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R1 reset state
        chk(alloc_ready == 1, "R1 alloc_ready", alloc_ready, 1);
        chk(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);
        chk(!disp_valid && !ret_valid && !exc_valid, "R1 outputs idle",
            {disp_valid, ret_valid, exc_valid}, 0);

        // single ready instruction
        alloc(4'd1, 1, 16'd5, 1, 16'd6, 5'd1, 16'h0011, 1, t);
        chk(t == 0, "R2 first tag", t, 0);
        chk(disp_valid && disp_tag == 0 && disp_op == 1, "R4 dispatch ready slot", {disp_valid, disp_tag}, {1'b1, 3'd0});
        chk(disp_opa == 5 && disp_opb == 6, "R11 present values", {disp_opa, disp_opb}, {16'd5, 16'd6});
        step();
        chk(!disp_valid, "R6 dispatched once", disp_valid, 0);
        complete(3'd0, 16'h0011, 0, 0);
        step();

        // pending source woken by broadcast
        alloc(4'd2, 1, 16'd2, 1, 16'd3, 5'd2, 16'h0040, 1, t);
        chk(t == 1, "R2 second tag", t, 1);
        alloc(4'd3, 0, 16'h0001, 1, 16'd7, 5'd3, 16'h0050, 1, t);
        chk(t == 2, "R2 third tag", t, 2);
        chk(!disp_valid, "R4 waiting source blocks dispatch", disp_valid, 0);
        complete(3'd1, 16'h0040, 0, 0);
        chk(disp_valid && disp_tag == 2, "R4 dispatch after wakeup", disp_tag, 2);
        chk(disp_opa == 16'h0040 && disp_opb == 7, "R7 R11 woken value", disp_opa, 16'h0040);
        step();
        complete(3'd2, 16'h0050, 0, 0);
        step();

        // broadcast in the allocation cycle
        alloc(4'd4, 1, 16'd1, 1, 16'd1, 5'd4, 16'h0077, 1, t);
        chk(t == 3, "R2 tag 3", t, 3);
        step();
        ei.is_exc = 0; ei.reg_no = 5'd5; ei.data = 16'h0088; ei.cause = 0;
        exp_q.push_back(ei);
        alloc_valid = 1; alloc_op = 4'd5; alloc_s1_rdy = 0; alloc_s1_fld = 16'h0003;
        alloc_s2_rdy = 1; alloc_s2_fld = 16'd9; alloc_dst_en = 1; alloc_dst_reg = 5'd5;
        cpl_valid = 1; cpl_tag = 3'd3; cpl_data = 16'h0077; cpl_exc = 0;
        #1;
        chk(alloc_tag == 4, "R2 tag 4", alloc_tag, 4);
        step();
        alloc_valid = 0; cpl_valid = 0;
        #1;
        chk(disp_valid && disp_tag == 4 && disp_opa == 16'h0077, "R8 same-cycle capture",
            {disp_tag, disp_opa}, {3'd4, 16'h0077});
        step();
        complete(3'd4, 16'h0088, 0, 0);
        step();

        // two slots woken together: oldest first, out-of-order completion
        alloc(4'd6, 1, 16'd1, 1, 16'd2, 5'd6, 16'h0021, 1, t);
        chk(t == 5, "R2 tag 5", t, 5);
        alloc(4'd7, 0, 16'h0005, 1, 16'h000A, 5'd7, 16'h0060, 1, t);
        alloc(4'd8, 0, 16'h0005, 1, 16'h000B, 5'd8, 16'h0070, 1, t);
        chk(t == 7, "R2 tag 7", t, 7);
        complete(3'd5, 16'h0021, 0, 0);
        chk(disp_valid && disp_tag == 6 && disp_opa == 16'h0021, "R5 oldest first", disp_tag, 6);
        step();
        chk(disp_valid && disp_tag == 7 && disp_opb == 16'h000B, "R5 younger next", disp_tag, 7);
        step();
        complete(3'd7, 16'h0070, 0, 0);
        chk(!ret_valid, "R9 no retire past unfinished head", ret_valid, 0);
        complete(3'd6, 16'h0060, 0, 0);
        repeat (3) step();

        // fill the window
        for (int k = 0; k < 8; k++) begin
            alloc(4'(k), 1, 16'(k), 1, 16'(k + 1), 5'(10 + k), 16'(16'h0100 + k), 1, t);
            chk(t == 3'(k), "R2 sequential tag", t, k);
        end
        chk(!alloc_ready, "R3 full stalls", alloc_ready, 0);
        alloc_valid = 1; alloc_dst_reg = 5'd31; alloc_s1_rdy = 1; alloc_s2_rdy = 1;
        step();
        alloc_valid = 0;
        #1;
        chk(!alloc_ready, "R3 still full", alloc_ready, 0);
        repeat (2) step();
        rc = ret_seen;
        for (int k = 7; k >= 1; k--) complete(3'(k), 16'(16'h0100 + k), 0, 0);
        chk(ret_seen == rc && !ret_valid, "R9 head blocks retire", ret_seen - rc, 0);
        complete(3'd0, 16'h0100, 0, 0);
        repeat (10) step();
        chk(ret_seen == rc + 8, "R9 all retired in order", ret_seen - rc, 8);
        chk(alloc_tag == 0 && alloc_ready, "R3 ignored request took no slot", alloc_tag, 0);

        // exception at the head
        ei.is_exc = 1; ei.reg_no = 5'd20; ei.data = 0; ei.cause = 4'd5;
        exp_q.push_back(ei);
        alloc(4'd9, 1, 16'd1, 1, 16'd1, 5'd20, 16'h0, 0, t);
        chk(t == 0, "R10 exc slot tag", t, 0);
        alloc(4'd10, 1, 16'd2, 1, 16'd2, 5'd21, 16'h0, 0, t);
        repeat (2) step();
        complete(3'd1, 16'h0099, 0, 0);
        complete(3'd0, 16'h0000, 1, 4'd5);
        chk(exc_valid && exc_cause == 5 && !ret_valid, "R10 exception raised", {exc_valid, exc_cause}, {1'b1, 4'd5});
        step();
        chk(alloc_tag == 0 && alloc_ready && !disp_valid, "R10 window emptied", alloc_tag, 0);
        alloc(4'd11, 1, 16'd3, 1, 16'd4, 5'd22, 16'h0033, 1, t);
        chk(t == 0, "R10 restart at tag 0", t, 0);
        chk(disp_valid && disp_tag == 0 && disp_opa == 3, "R10 R4 dispatch after flush", disp_tag, 0);
        step();
        complete(3'd0, 16'h0033, 0, 0);
        repeat (4) step();
        chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule